// File: doc/BRIEF.md
# Two-Way Registered Bus Transceiver

This block moves data between two parallel buses, side A and side B. It has one data path from A to B and a second, separate path from B to A. Each path has its own storage element and its own output enable. The storage element runs in one of three modes, chosen at run time by that path's latch-enable and strobe inputs. With latch enable high it is a pass-through. With latch enable low, a high-to-low change of the path's strobe captures the input. With latch enable low and the strobe steady, the stored word is kept.

Everything runs synchronously on a fast system clock, and the strobe is sampled as a level. The bus pins appear as separate input, output and per-bit output-enable vectors, so a wrapper can build tri-state pads from them. Each data input has a bus-hold keeper. A bit that no outside driver is driving reads as the last value that was driven onto it. The block raises a flag when both directions are driving at the same time. It flags this case and does not resolve it.

Top module: `bireg_xcvr`

## Requirements
- R1: While `rst_n` is low at a clock edge, both storage words and both bus-hold words clear to zero after that edge. Both output-enable vectors read zero until the first edge at which `rst_n` is high.
- R2: While a path's latch enable is high, that path's output equals its effective input in the same cycle. The storage word takes that input at every edge.
- R3: While a path's latch enable is low, a strobe that was 1 at the previous clock edge and is 0 at the current edge loads the effective input into the storage word. From then on the output shows that word.
- R4: While latch enable is low, a rising strobe or a steady strobe leaves the storage word and the output unchanged.
- R5: The A-to-B enable `ab_oe` is active high and drives every bit of `b_out_en`. The B-to-A enable `ba_oe_n` is active low and drives every bit of `a_out_en`. A disabled path drives all-zero enable bits.
- R6: Changing a path's output enable never changes its storage word. Re-enabling the path presents the word that is currently held.
- R7: For each input bit whose driven flag (`a_drv` / `b_drv`) is 0, the effective input is the value that bit last had while its flag was 1 (0 after reset).
- R8: `contention` is 1 exactly when both paths are enabled at the same time, after reset.
- R9: Neither path inverts data. One path's controls have no effect on the other path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | 18 | Value seen on side A pins |
| a_drv | input | 18 | Per-bit flag: side A bit is being driven from outside |
| b_in | input | 18 | Value seen on side B pins |
| b_drv | input | 18 | Per-bit flag: side B bit is being driven from outside |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ab_le | input | 1 | A-to-B latch enable |
| ab_cp | input | 1 | A-to-B capture strobe, captures on falling change |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable |
| ba_cp | input | 1 | B-to-A capture strobe, captures on falling change |
| b_out | output | 18 | Data to drive onto side B |
| b_out_en | output | 18 | Per-bit drive enable for side B |
| a_out | output | 18 | Data to drive onto side A |
| a_out_en | output | 18 | Per-bit drive enable for side A |
| contention | output | 1 | Both directions are enabled |

## Verification
The bench builds the block with its default width of 18. At that width every bit of both keepers and both storage words is visible, so partial driven masks such as alternating bits and the upper half can be checked bit by bit. A behavioural reference compares all outputs every cycle across the three storage modes, strobe rises and plateaus, enable toggling in both polarities, and the case where both directions drive at once.

// File: rtl/xcvr_pkg.sv
// Shared constants for the two-way registered bus transceiver.
// Assumes: nothing beyond IEEE 1800-2017.
package xcvr_pkg;
    localparam int unsigned XCVR_WIDTH = 18;
endpackage

// File: rtl/xcvr_hold.sv
// Bus-hold keeper for one side's input pins.
// What it does: passes driven bits through; undriven bits read the last driven value.
// Assumes: drv is a per-bit flag from the pad model, sampled on clk.
module xcvr_hold #(
    parameter int unsigned W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin,
    input  logic [W-1:0] drv,
    output logic [W-1:0] val
);
    logic [W-1:0] held;

    // Effective value: driven bits from the pins, the others from the keeper.
    always_comb val = (pin & drv) | (held & ~drv);

    // Keeper register follows the effective value.
    always_ff @(posedge clk) begin
        if (!rst_n) held <= '0;
        else        held <= val;
    end

    // R7: an undriven bit keeps its held level.
    p_keep_undriven_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (((held ^ $past(held)) & ~$past(drv)) == '0));
endmodule

// File: rtl/xcvr_lane.sv
// One direction of the transceiver: storage element, output mux and enable.
// What it does: pass-through when le is high, captures on a 1->0 change of cp
// when le is low, and holds otherwise. OE_LOW selects the enable polarity.
// Assumes: cp is a level sampled on clk; the enable is gated by 'ready'.
module xcvr_lane #(
    parameter int unsigned W      = 18,
    parameter bit          OE_LOW = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    input  logic         le,
    input  logic         cp,
    input  logic         oe,
    input  logic         ready,
    output logic [W-1:0] dout,
    output logic [W-1:0] dout_en
);
    logic [W-1:0] q;
    logic         cp_q;
    logic         fall;
    logic         act;

    // Select the enable polarity for this direction.
    generate
        if (OE_LOW) begin : g_low
            assign act = ~oe;
        end else begin : g_high
            assign act = oe;
        end
    endgenerate

    // Strobe falling change seen between two clock edges.
    always_comb fall = cp_q & ~cp;

    // Storage word and previous strobe level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            cp_q <= 1'b0;
        end else begin
            cp_q <= cp;
            if (le || fall) q <= d_in;
        end
    end

    // Output mux and per-bit enable.
    always_comb begin
        dout    = le ? d_in : q;
        dout_en = {W{act & ready}};
    end

    // R1: reset clears the storage word.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (q == '0));
    // R2: pass-through mode loads the input at every edge.
    p_transparent_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        le |=> (q == $past(d_in)));
    // R3: falling strobe with le low captures the input.
    p_fall_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!le && cp_q && !cp) |=> (q == $past(d_in)));
    // R4 and R6: no falling strobe with le low keeps the word, whatever oe does.
    p_no_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!le && !(cp_q && !cp)) |=> $stable(q));
endmodule

// File: rtl/bireg_xcvr.sv
// Top level of the two-way registered bus transceiver.
// What it does: bus-hold on both input sides, one lane per direction, and a
// flag when both directions drive at once.
// Assumes: synchronous active-low reset; outputs are disabled until the first
// edge after reset is released.
module bireg_xcvr
    import xcvr_pkg::*;
#(
    parameter int unsigned W = XCVR_WIDTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] a_drv,
    input  logic [W-1:0] b_in,
    input  logic [W-1:0] b_drv,
    input  logic         ab_oe,
    input  logic         ab_le,
    input  logic         ab_cp,
    input  logic         ba_oe_n,
    input  logic         ba_le,
    input  logic         ba_cp,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_out_en,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_out_en,
    output logic         contention
);
    logic [W-1:0] a_val;
    logic [W-1:0] b_val;
    logic         ready;

    // Ready flag: low during reset, high from the first edge after it.
    always_ff @(posedge clk) begin
        if (!rst_n) ready <= 1'b0;
        else        ready <= 1'b1;
    end

    xcvr_hold #(.W(W)) i_hold_a (
        .clk(clk), .rst_n(rst_n), .pin(a_in), .drv(a_drv), .val(a_val)
    );
    xcvr_hold #(.W(W)) i_hold_b (
        .clk(clk), .rst_n(rst_n), .pin(b_in), .drv(b_drv), .val(b_val)
    );

    xcvr_lane #(.W(W), .OE_LOW(1'b0)) i_lane_ab (
        .clk(clk), .rst_n(rst_n), .d_in(a_val), .le(ab_le), .cp(ab_cp),
        .oe(ab_oe), .ready(ready), .dout(b_out), .dout_en(b_out_en)
    );
    xcvr_lane #(.W(W), .OE_LOW(1'b1)) i_lane_ba (
        .clk(clk), .rst_n(rst_n), .d_in(b_val), .le(ba_le), .cp(ba_cp),
        .oe(ba_oe_n), .ready(ready), .dout(a_out), .dout_en(a_out_en)
    );

    // Both directions drive at once.
    always_comb contention = b_out_en[0] & a_out_en[0];

    // R1: outputs are disabled right after a reset edge.
    p_reset_disabled_r1: assert property (@(posedge clk)
        !rst_n |=> (b_out_en == '0 && a_out_en == '0));
    // R5: enable polarities of the two directions.
    p_oe_polarity_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((b_out_en == {W{ab_oe}}) && (a_out_en == {W{!ba_oe_n}})));
    // R8: both enabled raises the flag.
    p_contention_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ab_oe && !ba_oe_n) |-> contention);
endmodule

// File: tb/test_bireg_xcvr.sv
// Self-checking bench with a behavioural reference updated on every clock.
module test_bireg_xcvr;
    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0, a_drv = '1, b_in = '0, b_drv = '1;
    logic         ab_oe = 0, ab_le = 0, ab_cp = 0;
    logic         ba_oe_n = 1, ba_le = 0, ba_cp = 0;
    logic [W-1:0] b_out, b_out_en, a_out, a_out_en;
    logic         contention;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";

    // reference state
    logic [W-1:0] m_qab = '0, m_qba = '0, m_ha = '0, m_hb = '0;
    logic         m_cab = 0, m_cba = 0, m_rdy = 0;

    always #2 clk = ~clk;

    bireg_xcvr #(.W(W)) i_bireg_xcvr (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_drv(a_drv), .b_in(b_in), .b_drv(b_drv),
        .ab_oe(ab_oe), .ab_le(ab_le), .ab_cp(ab_cp), .ba_oe_n(ba_oe_n), .ba_le(ba_le),
        .ba_cp(ba_cp), .b_out(b_out), .b_out_en(b_out_en), .a_out(a_out),
        .a_out_en(a_out_en), .contention(contention)
    );

    function automatic logic [W-1:0] eff(input logic [W-1:0] p, input logic [W-1:0] d,
                                         input logic [W-1:0] h);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) r[i] = d[i] ? p[i] : h[i];
        return r;
    endfunction

    task automatic chk(input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic [W-1:0] ea, eb;
        logic en_b, en_a;
        ea = eff(a_in, a_drv, m_ha);
        eb = eff(b_in, b_drv, m_hb);
        en_b = m_rdy && ab_oe;
        en_a = m_rdy && !ba_oe_n;
        chk("b_out",    b_out,    ab_le ? ea : m_qab);
        chk("a_out",    a_out,    ba_le ? eb : m_qba);
        chk("b_out_en", b_out_en, en_b ? '1 : '0);
        chk("a_out_en", a_out_en, en_a ? '1 : '0);
        chk("contention", {{(W-1){1'b0}}, contention}, {{(W-1){1'b0}}, en_a && en_b});
    endtask

    // One clock: update the reference at the edge, compare after it, return at negedge.
    task automatic tick();
        logic [W-1:0] ea, eb;
        @(posedge clk);
        if (!rst_n) begin
            m_qab = '0; m_qba = '0; m_ha = '0; m_hb = '0;
            m_cab = 0; m_cba = 0; m_rdy = 0;
        end else begin
            ea = eff(a_in, a_drv, m_ha);
            eb = eff(b_in, b_drv, m_hb);
            if (ab_le || (m_cab && !ab_cp)) m_qab = ea;
            if (ba_le || (m_cba && !ba_cp)) m_qba = eb;
            m_cab = ab_cp; m_cba = ba_cp;
            m_ha = ea; m_hb = eb;
            m_rdy = 1;
        end
        #1;
        compare_all();
        @(negedge clk);
    endtask

    initial begin
        #(4 * 100000);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset with data and enables active
        cur_req = "R1";
        ab_oe = 1; ba_oe_n = 0; a_in = 18'h3ABCD;
        @(negedge clk);
        tick(); tick();
        chk("R1 b_out_en at reset", b_out_en, '0);
        chk("R1 b_out at reset", b_out, '0);
        ab_oe = 0; ba_oe_n = 1;
        rst_n = 1;
        tick();

        // R2, R5, R9: A-to-B pass-through with several patterns
        cur_req = "R2";
        ab_le = 1; ab_oe = 1;
        foreach (a_in[i]) begin end
        for (int k = 0; k < 6; k++) begin
            a_in = 18'h15555 ^ (18'(k) * 18'h0F0F3);
            tick();
        end
        cur_req = "R9";
        a_in = 18'h2AAAA; b_in = 18'h01234; ba_le = 1; ba_cp = 1;
        tick();
        chk("R9 non-inverting b_out", b_out, 18'h2AAAA);

        // R3: falling-strobe capture with le low
        cur_req = "R3";
        ab_le = 0; ab_cp = 1; a_in = 18'h11111;
        tick();
        a_in = 18'h0BEEF; ab_cp = 0;
        tick();
        chk("R3 captured", b_out, 18'h0BEEF);
        a_in = 18'h33333;
        tick();

        // R4: rising strobe and steady strobe do not capture
        cur_req = "R4";
        a_in = 18'h3C3C3; ab_cp = 1;
        tick();
        chk("R4 rise no capture", b_out, 18'h0BEEF);
        for (int k = 0; k < 3; k++) begin a_in = 18'(k * 7777); tick(); end
        ab_cp = 0; a_in = 18'h00F0F; tick();
        chk("R3 second fall", b_out, 18'h00F0F);
        for (int k = 0; k < 3; k++) begin a_in = 18'(k * 999 + 5); tick(); end

        // R6: enable toggling keeps the stored word
        cur_req = "R6";
        ab_oe = 0; a_in = 18'h12345; tick(); tick();
        chk("R6 disabled en", b_out_en, '0);
        ab_oe = 1; tick();
        chk("R6 re-enabled value", b_out, 18'h00F0F);

        // R5 and R8: B-to-A active-low enable, contention
        cur_req = "R5";
        ba_oe_n = 0; ab_oe = 0; ba_le = 1; b_in = 18'h2F00F; tick();
        chk("R5 a_out_en active low", a_out_en, '1);
        ba_oe_n = 1; tick();
        cur_req = "R8";
        ab_oe = 1; ba_oe_n = 0; tick(); tick();
        ab_oe = 0; tick();
        ab_oe = 1; ba_oe_n = 1; tick();

        // R9: B-to-A register mode while A-to-B controls move
        cur_req = "R9";
        ba_le = 0; ba_cp = 1; b_in = 18'h0CAFE; tick();
        ba_cp = 0; tick();
        ab_le = 1; ab_cp = 1; a_in = 18'h1FFFF; tick();
        ab_cp = 0; tick();
        chk("R9 independent a_out", a_out, 18'h0CAFE);

        // R7: bus hold on partial driven masks
        cur_req = "R7";
        ba_le = 1; ba_oe_n = 0; ab_oe = 1;
        b_in = 18'h3FFFF; b_drv = '1; tick();
        b_drv = 18'h15555; b_in = 18'h00000; tick();
        chk("R7 held odd bits", a_out, 18'h2AAAA);
        a_drv = 18'h3FE00; a_in = 18'h00000; tick();
        b_drv = '0; b_in = 18'h12345; tick(); tick();
        a_drv = '1; b_drv = '1; tick();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule